// File: doc/BRIEF.md
# Informing Load Data Cache

This block is a two-way set-associative data cache for the load path of a processor core. Every load carries a flag. An unflagged load behaves like a load to any ordinary cache. On a hit it returns the addressed word. On a miss it fetches the whole line from memory and then answers. A flagged (informing) load that hits behaves the same way. A flagged load that misses does not fetch the line. Instead it raises a one-cycle user-level trap that reports the full missing address and the set it maps to, and the load is held until software acknowledges the trap.

While the load is held, the trap handler can push a burst of preload requests through a separate prefetch port. Each preload that misses fills a line without trapping. A preload that finds its line already present is dropped. Once the handler acknowledges the trap, the held load looks up its line again. If the line is still missing, it is filled silently, and then the load returns its data. Replacement within a set is true least-recently-used.

Lines are 64 bytes and words are 32 bits, so a fill is sixteen beats. With the default of 16 sets, the line index is address bits [9:6] and the tag is bits [31:10]. The set count is a parameter and can be raised to the 256 sets of a 32 KB configuration.

Top module: `ilc_cache`

## Requirements
- R1: A synchronous active-high reset invalidates every line and clears every LRU bit. After reset, cpu_req_ready and pf_ready are high and trap_valid, cpu_resp_valid and mem_req_valid are low, so the first informing load to any address traps.
- R2: A load to a resident line answers with a single-cycle cpu_resp_valid pulse that carries the addressed 32-bit word (word select = address bits [5:2]). It makes no memory request.
- R3: An informing load that hits returns exactly the same data as an ordinary load. It raises no trap and makes no memory request.
- R4: An ordinary load that misses makes exactly one memory request. mem_req_addr is line aligned (bits [5:0] zero) and is held stable until mem_req_ready. The request is followed by sixteen fill beats carrying words 0 to 15 in ascending order. The load then answers with its word and never traps.
- R5: An informing load that misses drives trap_valid for exactly one cycle. trap_addr carries the full load address and trap_line carries its set index (address bits [9:6] by default). Until trap_ack, the cache makes no memory request for that load and gives no response.
- R6: After trap_ack, the held load's line is filled if it is still missing, and the load then answers with its word. Later loads to that line hit without a trap.
- R7: While a trap is waiting for trap_ack, prefetch requests are accepted. A missing preload fills its line and never traps. If a preload brings in the trapped line, the acknowledged load completes with no further memory request.
- R8: A preload whose line is already resident is dropped. It makes no memory request and leaves the set's LRU order unchanged.
- R9: Replacement is true LRU per set, with an invalid way filled first. Every completed fill (load or preload) and every load hit marks its way as most recent. A line never occupies both ways of a set.
- R10: When trap_ack and pf_valid arrive in the same waiting cycle, the acknowledge is taken and pf_ready is low. When cpu_req_valid and pf_valid arrive together in the idle state, the load is taken first and pf_ready is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req_valid | input | 1 | Load request present |
| cpu_req_ready | output | 1 | Load request accepted this cycle |
| cpu_req_addr | input | ADDR_W | Byte address of the load |
| cpu_req_inform | input | 1 | Load is an informing load |
| cpu_resp_valid | output | 1 | Load data valid (one cycle) |
| cpu_resp_data | output | WORD_W | Load data |
| trap_valid | output | 1 | Informing-miss trap pulse |
| trap_addr | output | ADDR_W | Address of the load that missed |
| trap_line | output | IDX_W | Set index of the missing line |
| trap_ack | input | 1 | Handler done; resume the held load |
| pf_valid | input | 1 | Preload request present |
| pf_ready | output | 1 | Preload request accepted this cycle |
| pf_addr | input | ADDR_W | Address inside the line to preload |
| mem_req_valid | output | 1 | Line fill request |
| mem_req_ready | input | 1 | Memory accepts the fill request |
| mem_req_addr | output | ADDR_W | Line-aligned fill address |
| mem_fill_valid | input | 1 | Fill beat valid |
| mem_fill_data | input | WORD_W | Fill beat word, ascending order |

## Verification
Two functions can collide in the same cycle. The first is the resumption of a trapped load through trap_ack while a handler preload is presented. The second is a new load meeting a preload in the idle state. The bench raises trap_ack and pf_valid on the same clock edge, then raises cpu_req_valid and pf_valid together. In each case it checks pf_ready low at that edge. It then checks from the order of the memory requests that the winning operation's line was fetched first, and that the deferred preload still completed later. A second overlap is a preload of the very line that trapped. That case is judged by the absence of any memory request after the acknowledge, together with correct load data.

// File: rtl/ilc_pkg.sv
package ilc_pkg;

    // Associativity is fixed: one LRU bit per set encodes the full order.
    localparam int ILC_WAYS       = 2;
    localparam int DEF_ADDR_W     = 32;
    localparam int DEF_WORD_W     = 32;
    localparam int DEF_LINE_BYTES = 64;
    localparam int DEF_SETS       = 16;

    typedef enum logic [2:0] {
        ST_IDLE,   // ready for a load or a preload
        ST_LOOK,   // tag compare on the current operation
        ST_WAIT,   // trap raised, load held until acknowledge
        ST_FREQ,   // presenting the line request to memory
        ST_FDATA   // collecting fill beats
    } ilc_state_e;

    // Invalid way first, then the least recently used one.
    function automatic logic pick_victim(input logic [ILC_WAYS-1:0] valid,
                                         input logic lru_way);
        if (!valid[0]) return 1'b0;
        if (!valid[1]) return 1'b1;
        return lru_way;
    endfunction

endpackage

// File: rtl/ilc_tag_array.sv
module ilc_tag_array import ilc_pkg::*; #(
    parameter int SETS  = DEF_SETS,
    parameter int IDX_W = $clog2(DEF_SETS),
    parameter int TAG_W = 22
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [IDX_W-1:0]    lk_idx,
    input  logic [TAG_W-1:0]    lk_tag,
    output logic [ILC_WAYS-1:0] hit_vec,
    output logic [ILC_WAYS-1:0] valid_vec,
    input  logic                wr_en,
    input  logic                wr_way,
    input  logic [IDX_W-1:0]    wr_idx,
    input  logic [TAG_W-1:0]    wr_tag
);

    for (genvar w = 0; w < ILC_WAYS; w++) begin : g_way
        logic [SETS-1:0]  valid_q;
        logic [TAG_W-1:0] tag_q [SETS];

        always_ff @(posedge clk) begin
            if (rst) begin
                valid_q <= '0;
            end else if (wr_en && wr_way == 1'(w)) begin
                valid_q[wr_idx] <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (wr_en && wr_way == 1'(w)) begin
                tag_q[wr_idx] <= wr_tag;
            end
        end

        assign valid_vec[w] = valid_q[lk_idx];
        assign hit_vec[w]   = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
    end

    AST_SINGLE_COPY: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_vec)); // R9

endmodule

// File: rtl/ilc_data_array.sv
module ilc_data_array import ilc_pkg::*; #(
    parameter int SETS   = DEF_SETS,
    parameter int WORDS  = 16,
    parameter int WORD_W = DEF_WORD_W,
    parameter int IDX_W  = $clog2(DEF_SETS),
    parameter int WOFF_W = 4
) (
    input  logic                             clk,
    input  logic [IDX_W-1:0]                 rd_idx,
    input  logic [WOFF_W-1:0]                rd_woff,
    output logic [ILC_WAYS-1:0][WORD_W-1:0]  rdata,
    input  logic                             wr_en,
    input  logic                             wr_way,
    input  logic [IDX_W-1:0]                 wr_idx,
    input  logic [WOFF_W-1:0]                wr_woff,
    input  logic [WORD_W-1:0]                wr_data
);

    localparam int DEPTH = SETS * WORDS;

    logic [IDX_W+WOFF_W-1:0] rd_a;
    logic [IDX_W+WOFF_W-1:0] wr_a;

    assign rd_a = {rd_idx, rd_woff};
    assign wr_a = {wr_idx, wr_woff};

    for (genvar w = 0; w < ILC_WAYS; w++) begin : g_way
        logic [WORD_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && wr_way == 1'(w)) begin
                mem[wr_a] <= wr_data;
            end
        end

        assign rdata[w] = mem[rd_a];
    end

endmodule

// File: rtl/ilc_lru.sv
module ilc_lru #(
    parameter int SETS  = 16,
    parameter int IDX_W = $clog2(16)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             lru_way,
    input  logic             touch_en,
    input  logic [IDX_W-1:0] touch_idx,
    input  logic             touch_way
);

    // Bit per set naming the least recently used way.
    logic [SETS-1:0] lru_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lru_q <= '0;
        end else if (touch_en) begin
            lru_q[touch_idx] <= ~touch_way;
        end
    end

    assign lru_way = lru_q[rd_idx];

endmodule

// File: rtl/ilc_cache.sv
module ilc_cache import ilc_pkg::*; #(
    parameter int ADDR_W     = DEF_ADDR_W,
    parameter int WORD_W     = DEF_WORD_W,
    parameter int LINE_BYTES = DEF_LINE_BYTES,
    parameter int SETS       = DEF_SETS,
    localparam int IDX_W     = $clog2(SETS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req_valid,
    output logic              cpu_req_ready,
    input  logic [ADDR_W-1:0] cpu_req_addr,
    input  logic              cpu_req_inform,
    output logic              cpu_resp_valid,
    output logic [WORD_W-1:0] cpu_resp_data,
    output logic              trap_valid,
    output logic [ADDR_W-1:0] trap_addr,
    output logic [IDX_W-1:0]  trap_line,
    input  logic              trap_ack,
    input  logic              pf_valid,
    output logic              pf_ready,
    input  logic [ADDR_W-1:0] pf_addr,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_fill_valid,
    input  logic [WORD_W-1:0] mem_fill_data
);

    localparam int WORD_BYTES = WORD_W / 8;
    localparam int WORDS      = LINE_BYTES / WORD_BYTES;
    localparam int BYTE_W     = $clog2(WORD_BYTES);
    localparam int WOFF_W     = $clog2(WORDS);
    localparam int OFF_W      = $clog2(LINE_BYTES);
    localparam int TAG_W      = ADDR_W - IDX_W - OFF_W;
    localparam logic [WOFF_W-1:0] LAST_BEAT = WOFF_W'(WORDS - 1);
    localparam logic [ADDR_W-1:0] LINE_MASK = ~ADDR_W'(LINE_BYTES - 1);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              inform;
        logic              acked;
    } ld_req_t;

    ilc_state_e        state_q;
    ld_req_t           ld_q;
    logic              ld_pend_q;
    logic              op_pf_q;
    logic [ADDR_W-1:0] pf_addr_q;
    logic              victim_q;
    logic [WOFF_W-1:0] beat_q;
    logic              resp_valid_q;
    logic [WORD_W-1:0] resp_data_q;
    logic              trap_valid_q;
    logic [ADDR_W-1:0] trap_addr_q;

    // Operation under lookup or fill: a preload or the held load.
    logic [ADDR_W-1:0] op_addr;
    logic [IDX_W-1:0]  op_idx;
    logic [TAG_W-1:0]  op_tag;
    logic [WOFF_W-1:0] op_woff;

    assign op_addr = op_pf_q ? pf_addr_q : ld_q.addr;
    assign op_idx  = op_addr[OFF_W +: IDX_W];
    assign op_tag  = op_addr[ADDR_W-1 -: TAG_W];
    assign op_woff = op_addr[BYTE_W +: WOFF_W];

    logic [ILC_WAYS-1:0]             hit_vec;
    logic [ILC_WAYS-1:0]             valid_vec;
    logic [ILC_WAYS-1:0][WORD_W-1:0] rdata;
    logic                            lru_way;
    logic                            hit;
    logic                            hit_way;
    logic                            fill_beat;
    logic                            fill_last;
    logic                            touch_en;
    logic                            touch_way;

    assign hit       = |hit_vec;
    assign hit_way   = hit_vec[1];
    assign fill_beat = (state_q == ST_FDATA) && mem_fill_valid;
    assign fill_last = fill_beat && (beat_q == LAST_BEAT);

    // A finished fill and a load hit both mark their way most recent.
    always_comb begin
        touch_en  = 1'b0;
        touch_way = victim_q;
        if (fill_last) begin
            touch_en  = 1'b1;
            touch_way = victim_q;
        end else if (state_q == ST_LOOK && !op_pf_q && hit) begin
            touch_en  = 1'b1;
            touch_way = hit_way;
        end
    end

    ilc_tag_array #(.SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
        .clk       (clk),
        .rst       (rst),
        .lk_idx    (op_idx),
        .lk_tag    (op_tag),
        .hit_vec   (hit_vec),
        .valid_vec (valid_vec),
        .wr_en     (fill_last),
        .wr_way    (victim_q),
        .wr_idx    (op_idx),
        .wr_tag    (op_tag)
    );

    ilc_data_array #(.SETS(SETS), .WORDS(WORDS), .WORD_W(WORD_W),
                     .IDX_W(IDX_W), .WOFF_W(WOFF_W)) u_data (
        .clk     (clk),
        .rd_idx  (op_idx),
        .rd_woff (op_woff),
        .rdata   (rdata),
        .wr_en   (fill_beat),
        .wr_way  (victim_q),
        .wr_idx  (op_idx),
        .wr_woff (beat_q),
        .wr_data (mem_fill_data)
    );

    ilc_lru #(.SETS(SETS), .IDX_W(IDX_W)) u_lru (
        .clk       (clk),
        .rst       (rst),
        .rd_idx    (op_idx),
        .lru_way   (lru_way),
        .touch_en  (touch_en),
        .touch_idx (op_idx),
        .touch_way (touch_way)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= ST_IDLE;
            ld_q         <= '0;
            ld_pend_q    <= 1'b0;
            op_pf_q      <= 1'b0;
            pf_addr_q    <= '0;
            victim_q     <= 1'b0;
            beat_q       <= '0;
            resp_valid_q <= 1'b0;
            resp_data_q  <= '0;
            trap_valid_q <= 1'b0;
            trap_addr_q  <= '0;
        end else begin
            resp_valid_q <= 1'b0;
            trap_valid_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (cpu_req_valid) begin
                        ld_q      <= '{addr: cpu_req_addr, inform: cpu_req_inform, acked: 1'b0};
                        ld_pend_q <= 1'b1;
                        op_pf_q   <= 1'b0;
                        state_q   <= ST_LOOK;
                    end else if (pf_valid) begin
                        pf_addr_q <= pf_addr;
                        op_pf_q   <= 1'b1;
                        state_q   <= ST_LOOK;
                    end
                end
                ST_LOOK: begin
                    if (op_pf_q) begin
                        if (hit) begin
                            state_q <= ld_pend_q ? ST_WAIT : ST_IDLE;
                        end else begin
                            victim_q <= pick_victim(valid_vec, lru_way);
                            state_q  <= ST_FREQ;
                        end
                    end else if (hit) begin
                        resp_valid_q <= 1'b1;
                        resp_data_q  <= rdata[hit_way];
                        ld_pend_q    <= 1'b0;
                        state_q      <= ST_IDLE;
                    end else if (ld_q.inform && !ld_q.acked) begin
                        trap_valid_q <= 1'b1;
                        trap_addr_q  <= ld_q.addr;
                        state_q      <= ST_WAIT;
                    end else begin
                        victim_q <= pick_victim(valid_vec, lru_way);
                        state_q  <= ST_FREQ;
                    end
                end
                ST_WAIT: begin
                    if (trap_ack) begin
                        ld_q.acked <= 1'b1;
                        op_pf_q    <= 1'b0;
                        state_q    <= ST_LOOK;
                    end else if (pf_valid) begin
                        pf_addr_q <= pf_addr;
                        op_pf_q   <= 1'b1;
                        state_q   <= ST_LOOK;
                    end
                end
                ST_FREQ: begin
                    if (mem_req_ready) begin
                        beat_q  <= '0;
                        state_q <= ST_FDATA;
                    end
                end
                ST_FDATA: begin
                    if (mem_fill_valid) begin
                        beat_q <= beat_q + 1'b1;
                        if (beat_q == LAST_BEAT) state_q <= ST_LOOK;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign cpu_req_ready  = (state_q == ST_IDLE);
    assign pf_ready       = ((state_q == ST_IDLE) && !cpu_req_valid) ||
                            ((state_q == ST_WAIT) && !trap_ack);
    assign cpu_resp_valid = resp_valid_q;
    assign cpu_resp_data  = resp_data_q;
    assign trap_valid     = trap_valid_q;
    assign trap_addr      = trap_addr_q;
    assign trap_line      = trap_addr_q[OFF_W +: IDX_W];
    assign mem_req_valid  = (state_q == ST_FREQ);
    assign mem_req_addr   = op_addr & LINE_MASK;

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!trap_valid && !cpu_resp_valid && cpu_req_ready)); // R1

    AST_TRAP_PULSE: assert property (@(posedge clk) disable iff (rst)
        trap_valid |=> !trap_valid); // R5

    AST_TRAP_HOLDS_LOAD: assert property (@(posedge clk) disable iff (rst)
        trap_valid |=> !cpu_resp_valid && !mem_req_valid); // R5

    AST_PLAIN_NO_TRAP: assert property (@(posedge clk) disable iff (rst)
        trap_valid |-> ld_q.inform); // R4

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R4

    AST_FILL_THEN_HIT: assert property (@(posedge clk) disable iff (rst)
        fill_last |=> hit); // R6

    AST_ACK_PRIORITY: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WAIT && trap_ack) |=> (state_q == ST_LOOK && !op_pf_q)); // R10

endmodule

// File: tb/ilc_cache_test.sv
module ilc_cache_test;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int NW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cpu_req_valid = 1'b0;
    logic          cpu_req_ready;
    logic [AW-1:0] cpu_req_addr = '0;
    logic          cpu_req_inform = 1'b0;
    logic          cpu_resp_valid;
    logic [DW-1:0] cpu_resp_data;
    logic          trap_valid;
    logic [AW-1:0] trap_addr;
    logic [3:0]    trap_line;
    logic          trap_ack = 1'b0;
    logic          pf_valid = 1'b0;
    logic          pf_ready;
    logic [AW-1:0] pf_addr = '0;
    logic          mem_req_valid;
    logic          mem_req_ready = 1'b0;
    logic [AW-1:0] mem_req_addr;
    logic          mem_fill_valid = 1'b0;
    logic [DW-1:0] mem_fill_data = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ilc_cache uut (
        .clk(clk), .rst(rst),
        .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
        .cpu_req_addr(cpu_req_addr), .cpu_req_inform(cpu_req_inform),
        .cpu_resp_valid(cpu_resp_valid), .cpu_resp_data(cpu_resp_data),
        .trap_valid(trap_valid), .trap_addr(trap_addr), .trap_line(trap_line),
        .trap_ack(trap_ack),
        .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_addr(pf_addr),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr),
        .mem_fill_valid(mem_fill_valid), .mem_fill_data(mem_fill_data)
    );

    int checks = 0;
    int errors = 0;
    int trap_cnt = 0;
    int resp_cnt = 0;
    int req_cnt = 0;
    logic [AW-1:0] last_trap_addr = '0;
    logic [3:0]    last_trap_line = '0;
    logic [DW-1:0] last_resp = '0;
    logic [AW-1:0] last_req = '0;
    logic [AW-1:0] req_log [64];

    function automatic logic [DW-1:0] model(input logic [AW-1:0] a);
        logic [AW-1:0] w;
        w = a & ~32'h3;
        return (w ^ 32'h5A5A_0000) + (w >> 7);
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Memory model: accepts a request, then streams sixteen ascending words.
    initial begin
        forever begin
            @(negedge clk);
            if (mem_req_valid) begin
                req_log[req_cnt % 64] = mem_req_addr;
                last_req = mem_req_addr;
                req_cnt++;
                mem_req_ready = 1'b1;
                @(negedge clk);
                mem_req_ready = 1'b0;
                for (int i = 0; i < NW; i++) begin
                    mem_fill_valid = 1'b1;
                    mem_fill_data  = model(last_req + 32'(i * 4));
                    @(negedge clk);
                end
                mem_fill_valid = 1'b0;
            end
        end
    end

    // Output monitor, sampled one time unit after each rising edge.
    always @(posedge clk) begin
        #1;
        if (trap_valid) begin
            trap_cnt++;
            last_trap_addr = trap_addr;
            last_trap_line = trap_line;
        end
        if (cpu_resp_valid) begin
            resp_cnt++;
            last_resp = cpu_resp_data;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=expired expected=finished");
        finish_run();
    end

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic load(input logic [AW-1:0] a, input bit inf);
        @(negedge clk);
        cpu_req_valid  = 1'b1;
        cpu_req_addr   = a;
        cpu_req_inform = inf;
        while (!cpu_req_ready) @(negedge clk);
        @(negedge clk);
        cpu_req_valid = 1'b0;
    endtask

    task automatic prefetch(input logic [AW-1:0] a);
        @(negedge clk);
        pf_valid = 1'b1;
        pf_addr  = a;
        #1;
        while (!pf_ready) @(negedge clk);
        @(negedge clk);
        pf_valid = 1'b0;
    endtask

    task automatic ack();
        @(negedge clk);
        trap_ack = 1'b1;
        @(negedge clk);
        trap_ack = 1'b0;
    endtask

    task automatic plain_load(input logic [AW-1:0] a, input bit inf,
                              input bit expect_miss, input string req);
        int r0, m0, t0;
        r0 = resp_cnt; m0 = req_cnt; t0 = trap_cnt;
        load(a, inf);
        wait_cycles(40);
        chk(req, "response count", 32'(resp_cnt - r0), 1);
        chk(req, "data", last_resp, model(a));
        chk(req, "trap count", 32'(trap_cnt - t0), 0);
        chk(req, "memory requests", 32'(req_cnt - m0), expect_miss ? 1 : 0);
        if (expect_miss) chk(req, "fill line address", last_req, a & ~32'h3F);
    endtask

    // Informing load that must miss: checks the trap and the held response.
    task automatic trap_load(input logic [AW-1:0] a, input string req);
        int r0, m0, t0;
        r0 = resp_cnt; m0 = req_cnt; t0 = trap_cnt;
        load(a, 1'b1);
        wait_cycles(12);
        chk(req, "trap pulses", 32'(trap_cnt - t0), 1);
        chk(req, "trap address", last_trap_addr, a);
        chk(req, "trap line", 32'(last_trap_line), 32'(a[9:6]));
        chk(req, "requests before ack", 32'(req_cnt - m0), 0);
        chk(req, "responses before ack", 32'(resp_cnt - r0), 0);
    endtask

    initial begin
        int r0, m0, t0;
        logic [AW-1:0] a;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state at the ports
        chk("R1", "cpu_req_ready", 32'(cpu_req_ready), 1);
        chk("R1", "pf_ready", 32'(pf_ready), 1);
        chk("R1", "trap_valid", 32'(trap_valid), 0);
        chk("R1", "cpu_resp_valid", 32'(cpu_resp_valid), 0);
        chk("R1", "mem_req_valid", 32'(mem_req_valid), 0);

        // R1, R5, R6: first informing load after reset traps, then completes
        trap_load(32'h0000_0000, "R1");
        m0 = req_cnt; r0 = resp_cnt;
        ack();
        wait_cycles(40);
        chk("R6", "requests after ack", 32'(req_cnt - m0), 1);
        chk("R6", "response after ack", 32'(resp_cnt - r0), 1);
        chk("R6", "data after ack", last_resp, model(32'h0));

        // R4: ordinary miss; R2 and R3: hits with both load kinds
        plain_load(32'h0000_1008, 1'b0, 1'b1, "R4");
        plain_load(32'h0000_1008, 1'b0, 1'b0, "R2");
        plain_load(32'h0000_1034, 1'b1, 1'b0, "R3");

        // R4: ordinary miss in every set
        for (int s = 0; s < 16; s++) begin
            plain_load(32'h0002_0000 + 32'(s * 64 + s * 4), 1'b0, 1'b1, "R4");
        end
        // R2/R3: every word of one line, alternating load kind (fill order)
        for (int w = 0; w < NW; w++) begin
            plain_load(32'h0002_00C0 + 32'(w * 4), 1'(w % 2), 1'b0, (w % 2) ? "R3" : "R2");
        end

        // R5/R6: informing miss, held load, acknowledge, fill, later hit
        a = 32'h0003_015C;
        trap_load(a, "R5");
        r0 = resp_cnt;
        wait_cycles(10);
        chk("R5", "still held", 32'(resp_cnt - r0), 0);
        m0 = req_cnt;
        ack();
        wait_cycles(40);
        chk("R6", "fill after ack", 32'(req_cnt - m0), 1);
        chk("R6", "fill address", last_req, a & ~32'h3F);
        chk("R6", "response", 32'(resp_cnt - r0), 1);
        chk("R6", "data", last_resp, model(a));
        plain_load(a + 4, 1'b1, 1'b0, "R6");

        // R7: preloads during the wait, including the trapped line itself
        a = 32'h0004_0250;
        trap_load(a, "R7");
        m0 = req_cnt; r0 = resp_cnt; t0 = trap_cnt;
        prefetch(32'h0004_0280);
        wait_cycles(40);
        chk("R7", "preload fill", 32'(req_cnt - m0), 1);
        chk("R7", "preload address", last_req, 32'h0004_0280);
        chk("R7", "no trap on preload", 32'(trap_cnt - t0), 0);
        chk("R7", "load still held", 32'(resp_cnt - r0), 0);
        prefetch(32'h0004_0240);
        wait_cycles(40);
        chk("R7", "trapped line preloaded", 32'(req_cnt - m0), 2);
        chk("R7", "trapped line address", last_req, 32'h0004_0240);
        ack();
        wait_cycles(40);
        chk("R7", "no request after ack", 32'(req_cnt - m0), 2);
        chk("R7", "response after ack", 32'(resp_cnt - r0), 1);
        chk("R7", "data after ack", last_resp, model(a));
        // R8: preload of a resident line is dropped
        m0 = req_cnt;
        prefetch(32'h0004_02A0);
        wait_cycles(20);
        chk("R8", "dropped preload", 32'(req_cnt - m0), 0);
        plain_load(32'h0004_02A4, 1'b1, 1'b0, "R7");

        // R10: acknowledge and preload in the same cycle
        a = 32'h0005_02E0;
        trap_load(a, "R10");
        m0 = req_cnt; r0 = resp_cnt;
        @(negedge clk);
        trap_ack = 1'b1;
        pf_valid = 1'b1;
        pf_addr  = 32'h0005_0380;
        #1;
        chk("R10", "pf_ready with ack", 32'(pf_ready), 0);
        @(negedge clk);
        trap_ack = 1'b0;
        #1;
        while (!pf_ready) @(negedge clk);
        @(negedge clk);
        pf_valid = 1'b0;
        wait_cycles(40);
        chk("R10", "two fills", 32'(req_cnt - m0), 2);
        chk("R10", "load line first", req_log[m0 % 64], a & ~32'h3F);
        chk("R10", "preload line second", req_log[(m0 + 1) % 64], 32'h0005_0380);
        chk("R10", "load data", last_resp, model(a));
        chk("R10", "one response", 32'(resp_cnt - r0), 1);

        // R10: load and preload together in idle
        m0 = req_cnt;
        @(negedge clk);
        cpu_req_valid  = 1'b1;
        cpu_req_addr   = 32'h000C_0184;
        cpu_req_inform = 1'b0;
        pf_valid = 1'b1;
        pf_addr  = 32'h000C_01C0;
        #1;
        chk("R10", "pf_ready with load", 32'(pf_ready), 0);
        chk("R10", "cpu_req_ready", 32'(cpu_req_ready), 1);
        @(negedge clk);
        cpu_req_valid = 1'b0;
        #1;
        while (!pf_ready) @(negedge clk);
        @(negedge clk);
        pf_valid = 1'b0;
        wait_cycles(40);
        chk("R10", "idle order first", req_log[m0 % 64], 32'h000C_0180);
        chk("R10", "idle order second", req_log[(m0 + 1) % 64], 32'h000C_01C0);
        chk("R10", "idle load data", last_resp, model(32'h000C_0184));

        // R9: true LRU in set 12 (sweep line already there)
        plain_load(32'h0006_0300, 1'b0, 1'b1, "R9");
        plain_load(32'h0007_0300, 1'b0, 1'b1, "R9");
        plain_load(32'h0006_0304, 1'b0, 1'b0, "R9");
        plain_load(32'h0008_0300, 1'b0, 1'b1, "R9");
        plain_load(32'h0006_0308, 1'b0, 1'b0, "R9");
        plain_load(32'h0007_0300, 1'b0, 1'b1, "R9");
        // R8: dropped preload of the LRU line leaves it least recent
        m0 = req_cnt;
        prefetch(32'h0006_0300);
        wait_cycles(20);
        chk("R8", "resident preload", 32'(req_cnt - m0), 0);
        plain_load(32'h0009_0300, 1'b0, 1'b1, "R8");
        plain_load(32'h0007_030C, 1'b0, 1'b0, "R8");
        plain_load(32'h0006_0300, 1'b0, 1'b1, "R8");

        // R9: a preload fill counts as a use (set 13)
        m0 = req_cnt;
        prefetch(32'h000A_0340);
        wait_cycles(40);
        chk("R9", "preload fill", 32'(req_cnt - m0), 1);
        plain_load(32'h000B_0344, 1'b0, 1'b1, "R9");
        plain_load(32'h000A_0348, 1'b1, 1'b0, "R9");
        plain_load(32'h0002_0374, 1'b0, 1'b1, "R9");

        finish_run();
    end

endmodule